// File: doc/BRIEF.md
# Three-Phase Carrier PWM Modulator with Selectable Offset Injection

This block turns three signed fixed-point phase voltage references for a two-level inverter into three switch commands. It adds the same common-mode offset to all three references, limits each result to the unit range, and compares it with one shared up/down triangle carrier. When a modified reference is at or above the carrier, that phase output is high.

The offset generator has four modes. The first adds no offset. The second centres the largest and smallest references symmetrically. The third pins the phase of greatest magnitude to a rail, so that phase does not switch for the whole carrier period. The fourth blends the minimum and maximum references using a zero-vector share that a start pulse ramps from zero up to one half. At one half, this mode behaves like the symmetric mode.

References arrive on a valid/ready stream. The block raises ready only in the cycle in which the carrier sits at its peak. A source that offers a new triple keeps valid and the three values steady until that cycle, and the block takes them at that clock edge. If no triple is offered at a peak, the block keeps the previous one. The offset mode, the ramp step and the start pulse are plain control pins, and the ramp-done flag is a plain status pin.

Top module: `zsi_pwm_mod`

## Requirements
- R1: References are signed REF_W-bit values with FRAC fractional bits, so unity is ONE = 2^FRAC. The carrier value is -ONE + k·INC with INC = 2·ONE/HALF_STEPS. The index k walks down from HALF_STEPS to 1 and then back up to HALF_STEPS, one step per clock, giving a period of 2·HALF_STEPS-2 clocks. After reset, k equals HALF_STEPS and is about to fall.
- R2: ref_ready is high exactly in the cycles where k equals HALF_STEPS. A triple is taken only when ref_valid and ref_ready are both high. The offset mode (0 none, 1 symmetric, 2 clamp, 3 soft start) is sampled at every peak edge. Modified references change only at peak edges, and a triple that is not accepted has no effect on the outputs.
- R3: In mode 0 the offset is zero.
- R4: In mode 1 the offset is floor(-(max+min)/2) of the three references.
- R5: In mode 2 the phase k with the largest absolute value is chosen, with ties won by a over b and b over c. The offset is ONE-s_k when s_k>=0, and -ONE-s_k otherwise.
- R6: In mode 3 the offset is 2·dz - ONE - floor(dz·max/ONE) + floor((dz-ONE)·min/ONE), using the dz held before the same peak edge.
- R7: Each modified reference is clamp(s+offset, -ONE, ONE). A phase output is high when its modified reference is greater than or equal to the current carrier value, so +ONE is always high and -ONE is always low.
- R8: The clock edge that samples start clears dz and ramp_done. Start has priority over a ramp step at the same edge. After that, each peak edge adds dz_step to dz, saturating at ONE/2. ramp_done rises at the edge where dz reaches ONE/2, and dz then stays there.
- R9: After reset, dz is 0, ramp_done is 0, the held references are 0, the mode is 0 and the carrier is at its peak. pwm is therefore 000 and ref_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference triple offered |
| ref_ready | output | 1 | High in the carrier peak cycle; triple taken then |
| ref_a | input | REF_W | Scaled reference, phase a (signed) |
| ref_b | input | REF_W | Scaled reference, phase b (signed) |
| ref_c | input | REF_W | Scaled reference, phase c (signed) |
| mode_sel | input | 2 | Offset mode, sampled at each peak |
| start | input | 1 | Pulse that restarts the zero-vector share ramp |
| dz_step | input | FRAC | Ramp increment per carrier period |
| ramp_done | output | 1 | Ramp has reached one half |
| pwm | output | 3 | Switch commands, bit 0 = a, 1 = b, 2 = c |

## Verification
The hardest case to reach from the ports is the exact cycle in which the ramp saturates. It must coincide with a peak, use the pre-update share for the offset of that period, and interact correctly with a start pulse that lands mid-ramp. The bench reaches it with directed start pulses at chosen ramp steps, one of which does not divide one half evenly, while the soft-start mode runs over random triples. Ties in magnitude for the clamp mode are driven deliberately, because random values almost never produce them.

// File: rtl/zsi_pwm_pkg.sv
package zsi_pwm_pkg;
  typedef enum logic [1:0] {
    ZS_NONE  = 2'd0,
    ZS_SYM   = 2'd1,
    ZS_CLAMP = 2'd2,
    ZS_SOFT  = 2'd3
  } zs_mode_e;

  localparam int NUM_PH = 3;
endpackage

// File: rtl/zsi_tri_carrier.sv
module zsi_tri_carrier #(
  parameter int REF_W      = 12,
  parameter int FRAC       = 10,
  parameter int HALF_STEPS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic signed [REF_W-1:0] carrier,
  output logic                    at_peak
);
  localparam int ONE_I = 1 << FRAC;
  localparam int INC   = (2 * ONE_I) / HALF_STEPS;
  localparam int KW    = $clog2(HALF_STEPS + 1);

  logic [KW-1:0] k_q;
  logic          up_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_q  <= KW'(HALF_STEPS);
      up_q <= 1'b0;
    end else if (up_q) begin
      k_q <= k_q + 1'b1;
      if (k_q + 1'b1 == KW'(HALF_STEPS)) up_q <= 1'b0;
    end else begin
      k_q <= k_q - 1'b1;
      if (k_q - 1'b1 == KW'(1)) up_q <= 1'b1;
    end
  end

  assign carrier = REF_W'(int'(k_q) * INC - ONE_I);
  assign at_peak = (k_q == KW'(HALF_STEPS));

  // R1: carrier stays in (-ONE, ONE]
  a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(carrier) <= ONE_I) && (int'(carrier) > -ONE_I));

  // R1: carrier moves by exactly one increment per clock
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int'(carrier) - int'($past(carrier)) == INC) ||
              (int'($past(carrier)) - int'(carrier) == INC)));
endmodule

// File: rtl/zsi_dz_ramp.sv
module zsi_dz_ramp #(
  parameter int FRAC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tick,
  input  logic [FRAC-1:0] step,
  output logic [FRAC-1:0] dz,
  output logic            done
);
  localparam logic [FRAC:0] HALF = (FRAC+1)'(1) << (FRAC - 1);

  logic          ramping_q;
  logic [FRAC:0] sum_w;

  assign sum_w = {1'b0, dz} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dz        <= '0;
      done      <= 1'b0;
      ramping_q <= 1'b0;
    end else if (start) begin
      dz        <= '0;
      done      <= 1'b0;
      ramping_q <= 1'b1;
    end else if (tick && ramping_q) begin
      if (sum_w >= HALF) begin
        dz        <= FRAC'(HALF);
        done      <= 1'b1;
        ramping_q <= 1'b0;
      end else begin
        dz <= sum_w[FRAC-1:0];
      end
    end
  end

  // R8: share never exceeds one half
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, dz} <= HALF);

  // R8: done implies the share is saturated
  a_r8_done_half: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, dz} == HALF));

  // R8: a start clears share and flag on the next cycle
  a_r8_start_clr: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dz == '0) && !done);
endmodule

// File: rtl/zsi_offset_gen.sv
module zsi_offset_gen
  import zsi_pwm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int FRAC  = 10
) (
  input  logic signed [REF_W-1:0] s_a,
  input  logic signed [REF_W-1:0] s_b,
  input  logic signed [REF_W-1:0] s_c,
  input  zs_mode_e                mode,
  input  logic [FRAC-1:0]         dz,
  output logic signed [REF_W+3:0] s0
);
  localparam int SW    = REF_W + 4;
  localparam int PW    = SW + FRAC + 2;
  localparam int ONE_I = 1 << FRAC;

  logic signed [SW-1:0] ea, eb, ec, mx, mn, aa, ab, ac, sk, neg_sum;
  logic signed [PW-1:0] dzs, mxp, mnp, p_hi, p_lo, soft_w;

  always_comb begin
    ea = SW'(s_a);
    eb = SW'(s_b);
    ec = SW'(s_c);

    mx = ea;
    if (eb > mx) mx = eb;
    if (ec > mx) mx = ec;
    mn = ea;
    if (eb < mn) mn = eb;
    if (ec < mn) mn = ec;

    aa = (ea < 0) ? -ea : ea;
    ab = (eb < 0) ? -eb : eb;
    ac = (ec < 0) ? -ec : ec;
    if (aa >= ab && aa >= ac) sk = ea;
    else if (ab >= ac)        sk = eb;
    else                      sk = ec;

    neg_sum = -(mx + mn);

    dzs    = $signed(PW'({1'b0, dz}));
    mxp    = PW'(mx);
    mnp    = PW'(mn);
    p_hi   = (dzs * mxp) >>> FRAC;
    p_lo   = ((dzs - PW'(ONE_I)) * mnp) >>> FRAC;
    soft_w = (dzs <<< 1) - PW'(ONE_I) - p_hi + p_lo;

    case (mode)
      ZS_NONE:  s0 = '0;
      ZS_SYM:   s0 = neg_sum >>> 1;
      ZS_CLAMP: s0 = ((sk < 0) ? -SW'(ONE_I) : SW'(ONE_I)) - sk;
      default:  s0 = SW'(soft_w);
    endcase
  end
endmodule

// File: rtl/zsi_pwm_mod.sv
module zsi_pwm_mod
  import zsi_pwm_pkg::*;
#(
  parameter int REF_W      = 12,
  parameter int FRAC       = 10,
  parameter int HALF_STEPS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_valid,
  output logic                    ref_ready,
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  input  logic [1:0]              mode_sel,
  input  logic                    start,
  input  logic [FRAC-1:0]         dz_step,
  output logic                    ramp_done,
  output logic [2:0]              pwm
);
  localparam int SW    = REF_W + 4;
  localparam int ONE_I = 1 << FRAC;

  logic signed [REF_W-1:0] carrier;
  logic                    at_peak;
  logic [FRAC-1:0]         dz;
  logic signed [SW-1:0]    s0;
  zs_mode_e                mode_q;

  logic signed [REF_W-1:0] ref_in  [NUM_PH];
  logic signed [REF_W-1:0] act_q   [NUM_PH];
  logic signed [REF_W-1:0] sel_ref [NUM_PH];
  logic signed [REF_W-1:0] mod_q   [NUM_PH];

  assign ref_in[0] = ref_a;
  assign ref_in[1] = ref_b;
  assign ref_in[2] = ref_c;
  assign ref_ready = at_peak;

  zsi_tri_carrier #(
    .REF_W(REF_W), .FRAC(FRAC), .HALF_STEPS(HALF_STEPS)
  ) u_carrier (
    .clk(clk), .rst_n(rst_n), .carrier(carrier), .at_peak(at_peak)
  );

  zsi_dz_ramp #(.FRAC(FRAC)) u_ramp (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(at_peak),
    .step(dz_step), .dz(dz), .done(ramp_done)
  );

  zsi_offset_gen #(.REF_W(REF_W), .FRAC(FRAC)) u_offset (
    .s_a(sel_ref[0]), .s_b(sel_ref[1]), .s_c(sel_ref[2]),
    .mode(zs_mode_e'(mode_sel)), .dz(dz), .s0(s0)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= ZS_NONE;
    else if (at_peak) mode_q <= zs_mode_e'(mode_sel);
  end

  for (genvar i = 0; i < NUM_PH; i++) begin : g_ph
    logic signed [SW-1:0]    sum_w;
    logic signed [REF_W-1:0] sat_w;

    assign sel_ref[i] = ref_valid ? ref_in[i] : act_q[i];
    assign sum_w      = SW'(sel_ref[i]) + s0;

    always_comb begin
      if (sum_w > SW'(ONE_I))       sat_w = REF_W'(ONE_I);
      else if (sum_w < -SW'(ONE_I)) sat_w = -REF_W'(ONE_I);
      else                          sat_w = REF_W'(sum_w);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_q[i] <= '0;
        mod_q[i] <= '0;
      end else if (at_peak) begin
        act_q[i] <= sel_ref[i];
        mod_q[i] <= sat_w;
      end
    end

    assign pwm[i] = (mod_q[i] >= carrier);

    // R2: modified reference only moves after a peak edge
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(at_peak) |-> $stable(mod_q[i]));

    // R7: a reference at the upper rail is always high
    a_r7_top: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(mod_q[i]) == ONE_I) |-> pwm[i]);

    // R7: a reference at the lower rail is always low
    a_r7_bot: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(mod_q[i]) == -ONE_I) |-> !pwm[i]);
  end

  // R5: clamp mode leaves one phase sitting on a rail
  a_r5_one_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ZS_CLAMP) |->
      ((int'(mod_q[0]) == ONE_I) || (int'(mod_q[0]) == -ONE_I) ||
       (int'(mod_q[1]) == ONE_I) || (int'(mod_q[1]) == -ONE_I) ||
       (int'(mod_q[2]) == ONE_I) || (int'(mod_q[2]) == -ONE_I)));
endmodule

// File: tb/zsi_pwm_mod_bench.sv
module zsi_pwm_mod_bench;
  localparam int REF_W = 12;
  localparam int FRAC  = 10;
  localparam int HS    = 32;
  localparam int ONE   = 1 << FRAC;
  localparam int INC   = (2 * ONE) / HS;
  localparam int HALF  = ONE / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_valid = 1'b0;
  logic ref_ready;
  logic signed [REF_W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic [1:0] mode_sel = 2'd0;
  logic start = 1'b0;
  logic [FRAC-1:0] dz_step = '0;
  logic ramp_done;
  logic [2:0] pwm;

  int checks = 0;
  int failures = 0;

  int m_k, m_mode, m_dz, m_step;
  bit m_up, m_ramp, m_done;
  int m_act [3];
  int m_mod [3];

  always #10 clk = ~clk;

  zsi_pwm_mod #(.REF_W(REF_W), .FRAC(FRAC), .HALF_STEPS(HS)) u_zsi_pwm_mod (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .mode_sel(mode_sel),
    .start(start), .dz_step(dz_step), .ramp_done(ramp_done), .pwm(pwm)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic int offset(input int a, input int b, input int c,
                                input int md, input int dz);
    int mx, mn, sk;
    mx = a; if (b > mx) mx = b; if (c > mx) mx = c;
    mn = a; if (b < mn) mn = b; if (c < mn) mn = c;
    case (md)
      0: return 0;
      1: return (-(mx + mn)) >>> 1;
      2: begin
        if ((a < 0 ? -a : a) >= (b < 0 ? -b : b) &&
            (a < 0 ? -a : a) >= (c < 0 ? -c : c)) sk = a;
        else if ((b < 0 ? -b : b) >= (c < 0 ? -c : c)) sk = b;
        else sk = c;
        return ((sk >= 0) ? ONE : -ONE) - sk;
      end
      default:
        return 2 * dz - ONE - ((dz * mx) >>> FRAC) + (((dz - ONE) * mn) >>> FRAC);
    endcase
  endfunction

  function automatic int clampv(input int v);
    if (v > ONE) return ONE;
    if (v < -ONE) return -ONE;
    return v;
  endfunction

  task automatic model_edge(input bit v, input int a, input int b, input int c,
                            input int md, input bit st);
    int s [3];
    int off;
    if (m_k == HS) begin
      if (v) begin m_act[0] = a; m_act[1] = b; m_act[2] = c; end
      s = m_act;
      off = offset(s[0], s[1], s[2], md, m_dz);
      for (int i = 0; i < 3; i++) m_mod[i] = clampv(s[i] + off);
      m_mode = md;
    end
    if (st) begin
      m_dz = 0; m_done = 0; m_ramp = 1;
    end else if (m_k == HS && m_ramp) begin
      if (m_dz + m_step >= HALF) begin
        m_dz = HALF; m_done = 1; m_ramp = 0;
      end else m_dz = m_dz + m_step;
    end
    if (m_up) begin
      m_k++; if (m_k == HS) m_up = 0;
    end else begin
      m_k--; if (m_k == 1) m_up = 1;
    end
  endtask

  task automatic compare();
    int car;
    string tg;
    car = -ONE + m_k * INC;
    for (int i = 0; i < 3; i++) begin
      if (m_mod[i] == ONE || m_mod[i] == -ONE) tg = "R7";
      else if (m_mode == 0) tg = "R3";
      else if (m_mode == 1) tg = "R4";
      else if (m_mode == 2) tg = "R5";
      else tg = "R6";
      chk(tg, int'(pwm[i]), (m_mod[i] >= car) ? 1 : 0);
    end
    chk("R2", int'(ref_ready), (m_k == HS) ? 1 : 0);
    chk("R8", int'(ramp_done), int'(m_done));
  endtask

  task automatic cyc(input bit v, input int a, input int b, input int c,
                     input int md, input bit st);
    ref_valid = v;
    ref_a = REF_W'(a); ref_b = REF_W'(b); ref_c = REF_W'(c);
    mode_sel = md[1:0];
    start = st;
    dz_step = FRAC'(m_step);
    @(posedge clk);
    model_edge(v, a, b, c, md, st);
    @(negedge clk);
    compare();
  endtask

  function automatic int rnd_ref();
    if ($urandom_range(0, 9) == 0)
      return ($urandom_range(0, 1) != 0) ? 2000 : -2000;
    return int'($urandom_range(0, 2600)) - 1300;
  endfunction

  task automatic rand_run(input int n, input int md);
    for (int j = 0; j < n; j++)
      cyc($urandom_range(0, 1) != 0, rnd_ref(), rnd_ref(), rnd_ref(), md, 1'b0);
  endtask

  task automatic wait_peak(input int md);
    while (m_k != HS) cyc(1'b0, 0, 0, 0, md, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    int ws;
    void'($urandom(32'h5EED_0042));
    m_k = HS; m_up = 0; m_mode = 0; m_dz = 0; m_step = 0;
    m_ramp = 0; m_done = 0;
    for (int i = 0; i < 3; i++) begin m_act[i] = 0; m_mod[i] = 0; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    chk("R9", int'(pwm), 0);
    chk("R9", int'(ref_ready), 1);
    chk("R9", int'(ramp_done), 0);

    // R1: peak-to-peak spacing
    cyc(1'b0, 0, 0, 0, 0, 1'b0);
    cnt = 1;
    while (!ref_ready && cnt < 1000) begin
      cyc(1'b0, 0, 0, 0, 0, 1'b0);
      cnt++;
    end
    chk("R1", cnt, 2 * HS - 2);

    // R2: triple offered off-peak is not taken; outputs follow held values
    cyc(1'b1, 900, -900, 900, 0, 1'b0);
    chk("R2", int'(ref_ready), 0);
    wait_peak(0);
    cyc(1'b1, 300, -300, 0, 0, 1'b0);
    rand_run(400, 0);

    // R4: symmetric mode
    rand_run(400, 1);

    // R5: clamp mode with magnitude ties
    wait_peak(2);
    cyc(1'b1, -500, 500, 500, 2, 1'b0);
    rand_run(70, 2);
    wait_peak(2);
    cyc(1'b1, 200, -700, 700, 2, 1'b0);
    rand_run(70, 2);
    wait_peak(2);
    cyc(1'b1, 0, 0, 0, 2, 1'b0);
    rand_run(400, 2);

    // R6/R8: soft start ramps, step 100 (not dividing one half)
    m_step = 100;
    cyc(1'b0, 0, 0, 0, 3, 1'b1);
    rand_run(500, 3);
    chk("R8", int'(ramp_done), 1);

    // R8: start mid-ramp restarts, step 128
    m_step = 128;
    cyc(1'b0, 0, 0, 0, 3, 1'b1);
    rand_run(100, 3);
    cyc(1'b0, 0, 0, 0, 3, 1'b1);
    chk("R8", int'(ramp_done), 0);
    rand_run(400, 3);

    // R8: start landing on a peak edge wins over the step
    wait_peak(3);
    cyc(1'b1, 400, -100, -300, 3, 1'b1);
    rand_run(300, 3);

    // R6: all-zero references, offset follows share alone
    m_step = 37;
    wait_peak(3);
    cyc(1'b1, 0, 0, 0, 3, 1'b1);
    ws = 0;
    while (ws < 700) begin cyc(1'b0, 0, 0, 0, 3, 1'b0); ws++; end

    // mode switching at random peaks
    for (int j = 0; j < 8; j++) rand_run(90, int'($urandom_range(0, 3)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule